// File: doc/BRIEF.md
# Shared-Multiplier FFT/FIR Engine

This block is a complex-valued DSP engine with two run modes: an in-place radix-2 decimation-in-time FFT, and a short complex FIR filter applied in place over a block of samples. Every real product in both modes goes through one 18x18 signed multiplier. Each complex product is therefore spread over four consecutive multiplier cycles into a pair of accumulators. Samples are held in a dual-ported data memory. Twiddles (FFT) or taps (FIR) are held in a single-ported coefficient memory. Both memories share the same address generators and ALUs in the two modes.

A host fills the memories through a simple write port while the engine is idle. It sets the mode and pulses start, then waits for the one-cycle done pulse. It reads the results back through a registered read port. Before its butterfly stages, the FFT reorders the natural-order input into bit-reversed order itself. Its results land in natural order, and each butterfly halves its outputs so that no stage can overflow. The FIR walks its outputs from the highest index down, so each result can overwrite its own input slot without disturbing inputs that are still needed.

Top module: `fftfir_engine`

## Requirements
- R1: While reset is held and after its release, busy and done are 0.
- R2: While idle, hostWe=1 writes {hostWrRe, hostWrIm} at hostAddr into the data memory when hostSel=0, or into the coefficient memory when hostSel=1. The data word at hostRdAddr appears on hostRdRe/hostRdIm one clock edge after the address is presented.
- R3: With mode=0 (FFT), the engine first bit-reverses the sample order and then runs LOG2N radix-2 stages. Stage s, butterfly b (0..N/2-1) has j = b mod 2^s, top = (b div 2^s)*2^(s+1) + j and bottom = top + 2^s. It uses the twiddle W at coefficient address j*N/2^(s+1) and forms T = W*B exactly. It writes top = sat(floor((A*2^17 + T + 2^17)/2^18)) and bottom = sat(floor((A*2^17 - T + 2^17)/2^18)) per real and imaginary part. Results are left in natural order.
- R4: With mode=1 (FIR), every sample n from N-1 down to 0 is replaced by sat(floor((sum over k=0..min(TAPS-1,n) of h[k]*x[n-k] + 2^16)/2^17)), using the original x. Tap h[k] is taken from coefficient address k, and the complex product is (hr*xr - hi*xi, hr*xi + hi*xr).
- R5: A start seen while idle makes busy high from the next cycle. busy stays high until the run completes. done is then high for exactly one cycle, in the first cycle that busy is low.
- R6: The busy time is exactly 2N + 3N*LOG2N cycles for an FFT. For a FIR it is the sum over n of (2 + 4*min(TAPS, n+1)) cycles.
- R7: start, mode and host writes presented while busy are ignored. The run completes once, with the results it would have produced without them.
- R8: Results are limited to the 18-bit two's-complement range: above 131071 gives 131071, and below -131072 gives -131072.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | Run mode sampled at start: 0 FFT, 1 FIR |
| start | input | 1 | Start pulse, honoured only when idle |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when a run completes |
| hostWe | input | 1 | Host write strobe, honoured only when idle |
| hostSel | input | 1 | Write target: 0 data memory, 1 coefficient memory |
| hostAddr | input | LOG2N | Host write address |
| hostWrRe | input | DW | Real part to write |
| hostWrIm | input | DW | Imaginary part to write |
| hostRdAddr | input | LOG2N | Data memory read address while idle |
| hostRdRe | output | DW | Real part read back, one cycle after the address |
| hostRdIm | output | DW | Imaginary part read back, one cycle after the address |

## Verification
The start handshake and the completion pulse can fall in the same cycle. A new start may arrive in the very cycle that done is high, because the engine is already idle then. The bench provokes this by raising start in the done cycle of a FIR pass, which chains an FFT directly onto the filtered data. It judges the result by comparing the final memory against the FIR model followed by the FFT model, and by checking the busy length of the second run. A second overlap is also exercised: start and host writes are driven mid-run, and the bench shows they changed neither the results nor the run length.

// File: rtl/fftfir_pkg.sv
package fftfir_pkg;

  typedef enum logic [1:0] {
    WR_NONE,
    WR_BFLY,
    WR_SWAP,
    WR_FIR
  } wrKind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_REV_RD, S_REV_WR, S_BF_RD,
    S_MUL0, S_MUL1, S_MUL2, S_MUL3,
    S_BF_WR, S_FIR_RD, S_FIR_WR
  } state_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic     busy;
    logic     firOp;   // multiplier X operand from port A instead of port B
    logic     mulEn;
    logic     accClr;  // start a fresh complex product
    logic [1:0] mulSel; // 0 wr*xr(+re) 1 wi*xi(-re) 2 wr*xi(+im) 3 wi*xr(+im)
    wrKind_e  wrKind;
  } strobe_t;

endpackage

// File: rtl/fftfir_ctrl.sv
module fftfir_ctrl
  import fftfir_pkg::*;
#(
  parameter int LOG2N = 6,
  parameter int TAPS  = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             mode,
  output strobe_t          strobe,
  output logic [LOG2N-1:0] addrA,
  output logic [LOG2N-1:0] addrB,
  output logic [LOG2N-1:0] addrW,
  output logic             done
);
  localparam int N  = 1 << LOG2N;
  localparam int AW = LOG2N;
  localparam int SW = $clog2(LOG2N) + 1;
  localparam int TW = $clog2(TAPS) + 1;

  state_e        state;
  logic          modeFir;
  logic [AW-1:0] idx;
  logic [SW-1:0] stage;
  logic [TW-1:0] tap;

  // address generators: bit-reverse, butterfly top/bottom, twiddle, FIR tap
  logic [AW-1:0] revIdx, half, jLow, topAddr, botAddr, twAddr, firAddr;
  logic [TW-1:0] tapNext;

  for (genvar g = 0; g < AW; g++) begin : gRev
    assign revIdx[g] = idx[AW-1-g];
  end

  always_comb begin
    half    = AW'(1) << stage;
    jLow    = idx & (half - AW'(1));
    topAddr = ((idx >> stage) << (stage + SW'(1))) | jLow;
    botAddr = topAddr | half;
    twAddr  = jLow << (SW'(AW - 1) - stage);
    tapNext = (state == S_MUL3) ? tap + TW'(1) : tap;
    firAddr = idx - AW'(tapNext);
  end

  always_comb begin
    addrA = topAddr;
    addrB = botAddr;
    addrW = twAddr;
    if (modeFir) begin
      addrA = (state == S_FIR_WR) ? idx : firAddr;
      addrB = idx;
      addrW = AW'(tapNext);
    end else if (state == S_REV_RD || state == S_REV_WR) begin
      addrA = idx;
      addrB = revIdx;
    end
  end

  logic isMul, lastTap;
  assign isMul   = (state == S_MUL0) || (state == S_MUL1) ||
                   (state == S_MUL2) || (state == S_MUL3);
  assign lastTap = (tap == TW'(TAPS - 1)) || (int'(tap) == int'(idx));

  always_comb begin
    strobe.busy   = (state != S_IDLE);
    strobe.firOp  = modeFir;
    strobe.mulEn  = isMul;
    strobe.mulSel = 2'(state - S_MUL0);
    strobe.accClr = (state == S_MUL0) && (!modeFir || tap == '0);
    case (state)
      S_REV_WR: strobe.wrKind = (idx < revIdx) ? WR_SWAP : WR_NONE;
      S_BF_WR:  strobe.wrKind = WR_BFLY;
      S_FIR_WR: strobe.wrKind = WR_FIR;
      default:  strobe.wrKind = WR_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      modeFir <= 1'b0;
      idx     <= '0;
      stage   <= '0;
      tap     <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          modeFir <= mode;
          tap     <= '0;
          stage   <= '0;
          if (mode) begin
            idx   <= AW'(N - 1);
            state <= S_FIR_RD;
          end else begin
            idx   <= '0;
            state <= S_REV_RD;
          end
        end
        S_REV_RD: state <= S_REV_WR;
        S_REV_WR: begin
          idx   <= idx + AW'(1);
          state <= (idx == AW'(N - 1)) ? S_BF_RD : S_REV_RD;
        end
        S_BF_RD, S_FIR_RD: state <= S_MUL0;
        S_MUL0: state <= S_MUL1;
        S_MUL1: state <= S_MUL2;
        S_MUL2: state <= S_MUL3;
        S_MUL3: begin
          if (!modeFir) state <= S_BF_WR;
          else if (lastTap) state <= S_FIR_WR;
          else begin
            tap   <= tapNext;
            state <= S_MUL0;
          end
        end
        S_BF_WR: begin
          if (idx == AW'(N / 2 - 1)) begin
            idx <= '0;
            if (stage == SW'(LOG2N - 1)) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              stage <= stage + SW'(1);
              state <= S_BF_RD;
            end
          end else begin
            idx   <= idx + AW'(1);
            state <= S_BF_RD;
          end
        end
        S_FIR_WR: begin
          tap <= '0;
          if (idx == '0) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            idx   <= idx - AW'(1);
            state <= S_FIR_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fftfir_dp.sv
module fftfir_dp
  import fftfir_pkg::*;
#(
  parameter int LOG2N = 6,
  parameter int DW    = 18,
  parameter int ACCW  = 43
) (
  input  logic             clk,
  input  strobe_t          strobe,
  input  logic [LOG2N-1:0] addrA,
  input  logic [LOG2N-1:0] addrB,
  input  logic [LOG2N-1:0] addrW,
  input  logic             hostWe,
  input  logic             hostSel,
  input  logic [LOG2N-1:0] hostAddr,
  input  logic [DW-1:0]    hostWrRe,
  input  logic [DW-1:0]    hostWrIm,
  input  logic [LOG2N-1:0] hostRdAddr,
  output logic [DW-1:0]    rdRe,
  output logic [DW-1:0]    rdIm
);
  localparam int N    = 1 << LOG2N;
  localparam int FRAC = DW - 1;
  localparam int PW   = 2 * DW;
  localparam logic signed [ACCW-1:0] MAXV    = ACCW'((64'sd1 <<< (DW - 1)) - 64'sd1);
  localparam logic signed [ACCW-1:0] MINV    = -MAXV - ACCW'(1);
  localparam logic signed [ACCW-1:0] RND_BF  = ACCW'(64'sd1 <<< FRAC);
  localparam logic signed [ACCW-1:0] RND_FIR = ACCW'(64'sd1 <<< (FRAC - 1));

  logic [2*DW-1:0] dmem [N];
  logic [2*DW-1:0] cmem [N];
  logic [2*DW-1:0] qA, qB, qW, wdA, wdB;
  logic [LOG2N-1:0] rdAddrA, addrPortB, addrPortC;
  logic weA, weB, weC;

  assign rdAddrA   = strobe.busy ? addrA : hostRdAddr;
  assign addrPortB = strobe.busy ? addrB : hostAddr;
  assign addrPortC = strobe.busy ? addrW : hostAddr;
  assign weC       = !strobe.busy && hostWe && hostSel;

  always_ff @(posedge clk) begin
    if (weA) dmem[addrA] <= wdA;
    if (weB) dmem[addrPortB] <= wdB;
    qA <= dmem[rdAddrA];
    qB <= dmem[addrPortB];
  end

  always_ff @(posedge clk) begin
    if (weC) cmem[addrPortC] <= {hostWrRe, hostWrIm};
    qW <= cmem[addrPortC];
  end

  // single shared multiplier
  logic signed [DW-1:0] aRe, aIm, wRe, wIm, xRe, xIm, mulL, mulR;
  logic signed [PW-1:0] prod;
  logic signed [ACCW-1:0] prodExt, accRe, accIm, accBase;

  assign {aRe, aIm} = qA;
  assign {wRe, wIm} = qW;
  assign {xRe, xIm} = strobe.firOp ? qA : qB;

  always_comb begin
    case (strobe.mulSel)
      2'd0:    begin mulL = wRe; mulR = xRe; end
      2'd1:    begin mulL = wIm; mulR = xIm; end
      2'd2:    begin mulL = wRe; mulR = xIm; end
      default: begin mulL = wIm; mulR = xRe; end
    endcase
    prod    = mulL * mulR;
    prodExt = {{(ACCW-PW){prod[PW-1]}}, prod};
    accBase = strobe.accClr ? '0 : accRe;
  end

  always_ff @(posedge clk) begin
    if (strobe.mulEn) begin
      case (strobe.mulSel)
        2'd0: begin
          accRe <= accBase + prodExt;
          if (strobe.accClr) accIm <= '0;
        end
        2'd1:    accRe <= accRe - prodExt;
        default: accIm <= accIm + prodExt;
      endcase
    end
  end

  function automatic logic [DW-1:0] satDw(input logic signed [ACCW-1:0] v);
    if (v > MAXV) return MAXV[DW-1:0];
    if (v < MINV) return MINV[DW-1:0];
    return v[DW-1:0];
  endfunction

  // butterfly and FIR output ALUs
  logic signed [ACCW-1:0] aScRe, aScIm;
  logic [DW-1:0] topRe, topIm, botRe, botIm, firRe, firIm;

  always_comb begin
    aScRe = {{(ACCW-DW){aRe[DW-1]}}, aRe} <<< FRAC;
    aScIm = {{(ACCW-DW){aIm[DW-1]}}, aIm} <<< FRAC;
    topRe = satDw((aScRe + accRe + RND_BF) >>> (FRAC + 1));
    topIm = satDw((aScIm + accIm + RND_BF) >>> (FRAC + 1));
    botRe = satDw((aScRe - accRe + RND_BF) >>> (FRAC + 1));
    botIm = satDw((aScIm - accIm + RND_BF) >>> (FRAC + 1));
    firRe = satDw((accRe + RND_FIR) >>> FRAC);
    firIm = satDw((accIm + RND_FIR) >>> FRAC);
  end

  always_comb begin
    weA = 1'b0;
    weB = !strobe.busy && hostWe && !hostSel;
    wdA = {firRe, firIm};
    wdB = {hostWrRe, hostWrIm};
    case (strobe.wrKind)
      WR_BFLY: begin
        weA = 1'b1; wdA = {topRe, topIm};
        weB = 1'b1; wdB = {botRe, botIm};
      end
      WR_SWAP: begin
        weA = 1'b1; wdA = qB;
        weB = 1'b1; wdB = qA;
      end
      WR_FIR:  weA = 1'b1;
      default: ;
    endcase
  end

  assign rdRe = qA[2*DW-1:DW];
  assign rdIm = qA[DW-1:0];

endmodule

// File: rtl/fftfir_engine.sv
module fftfir_engine
  import fftfir_pkg::*;
#(
  parameter int LOG2N = 6,
  parameter int TAPS  = 10,
  parameter int DW    = 18,
  parameter int ACCW  = 2 * DW + $clog2(TAPS) + 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mode,
  input  logic             start,
  output logic             busy,
  output logic             done,
  input  logic             hostWe,
  input  logic             hostSel,
  input  logic [LOG2N-1:0] hostAddr,
  input  logic [DW-1:0]    hostWrRe,
  input  logic [DW-1:0]    hostWrIm,
  input  logic [LOG2N-1:0] hostRdAddr,
  output logic [DW-1:0]    hostRdRe,
  output logic [DW-1:0]    hostRdIm
);
  strobe_t          strobe;
  logic [LOG2N-1:0] addrA, addrB, addrW;

  fftfir_ctrl #(.LOG2N(LOG2N), .TAPS(TAPS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .strobe(strobe), .addrA(addrA), .addrB(addrB), .addrW(addrW), .done(done)
  );

  fftfir_dp #(.LOG2N(LOG2N), .DW(DW), .ACCW(ACCW)) u_dp (
    .clk(clk), .strobe(strobe), .addrA(addrA), .addrB(addrB), .addrW(addrW),
    .hostWe(hostWe), .hostSel(hostSel), .hostAddr(hostAddr),
    .hostWrRe(hostWrRe), .hostWrIm(hostWrIm), .hostRdAddr(hostRdAddr),
    .rdRe(hostRdRe), .rdIm(hostRdIm)
  );

  assign busy = strobe.busy;

endmodule

// File: rtl/fftfir_chk.sv
module fftfir_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R5
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R5
  AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R7
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy)); // R5
endmodule

bind fftfir_engine fftfir_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done)
);

// File: tb/sim_fftfir_engine.sv
module sim_fftfir_engine;
  localparam int LOG2N = 6;
  localparam int N     = 1 << LOG2N;
  localparam int TAPS  = 10;
  localparam int DW    = 18;

  logic clk = 1'b0, rstN = 1'b0, mode = 1'b0, start = 1'b0;
  logic busy, done;
  logic hostWe = 1'b0, hostSel = 1'b0;
  logic [LOG2N-1:0] hostAddr = '0, hostRdAddr = '0;
  logic [DW-1:0] hostWrRe = '0, hostWrIm = '0, hostRdRe, hostRdIm;

  fftfir_engine #(.LOG2N(LOG2N), .TAPS(TAPS), .DW(DW)) u0 (
    .clk(clk), .rstN(rstN), .mode(mode), .start(start), .busy(busy), .done(done),
    .hostWe(hostWe), .hostSel(hostSel), .hostAddr(hostAddr),
    .hostWrRe(hostWrRe), .hostWrIm(hostWrIm), .hostRdAddr(hostRdAddr),
    .hostRdRe(hostRdRe), .hostRdIm(hostRdIm)
  );

  always #4 clk = ~clk;

  int nChecks = 0, nFails = 0;
  int dRe[N], dIm[N], cRe[N], cIm[N];

  task automatic check(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL R5 watchdog: actual running expected finished");
    summary();
    $finish;
  end

  function automatic int sat(input longint v);
    if (v > 131071) return 131071;
    if (v < -131072) return -131072;
    return int'(v);
  endfunction

  function automatic int rnd18();
    return int'($urandom_range(0, 262143)) - 131072;
  endfunction

  function automatic int bitrev(input int i);
    int r = 0;
    for (int b = 0; b < LOG2N; b++) if (i[b]) r |= 1 << (LOG2N - 1 - b);
    return r;
  endfunction

  task automatic modelFft();
    for (int i = 0; i < N; i++) begin
      int j = bitrev(i);
      if (i < j) begin
        int t;
        t = dRe[i]; dRe[i] = dRe[j]; dRe[j] = t;
        t = dIm[i]; dIm[i] = dIm[j]; dIm[j] = t;
      end
    end
    for (int s = 0; s < LOG2N; s++) begin
      int half = 1 << s;
      for (int b = 0; b < N / 2; b++) begin
        int jl  = b % half;
        int top = (b / half) * 2 * half + jl;
        int bot = top + half;
        int tw  = jl * (N / (2 * half));
        longint tr = longint'(cRe[tw]) * dRe[bot] - longint'(cIm[tw]) * dIm[bot];
        longint ti = longint'(cRe[tw]) * dIm[bot] + longint'(cIm[tw]) * dRe[bot];
        longint ar = longint'(dRe[top]) * 131072;
        longint ai = longint'(dIm[top]) * 131072;
        dRe[top] = sat((ar + tr + 131072) >>> 18);
        dIm[top] = sat((ai + ti + 131072) >>> 18);
        dRe[bot] = sat((ar - tr + 131072) >>> 18);
        dIm[bot] = sat((ai - ti + 131072) >>> 18);
      end
    end
  endtask

  task automatic modelFir();
    int xr[N], xi[N];
    for (int i = 0; i < N; i++) begin xr[i] = dRe[i]; xi[i] = dIm[i]; end
    for (int n = 0; n < N; n++) begin
      longint accR = 0, accI = 0;
      for (int k = 0; k < TAPS && k <= n; k++) begin
        accR += longint'(cRe[k]) * xr[n-k] - longint'(cIm[k]) * xi[n-k];
        accI += longint'(cRe[k]) * xi[n-k] + longint'(cIm[k]) * xr[n-k];
      end
      dRe[n] = sat((accR + 65536) >>> 17);
      dIm[n] = sat((accI + 65536) >>> 17);
    end
  endtask

  function automatic int firCycles();
    int c = 0;
    for (int n = 0; n < N; n++) c += 2 + 4 * ((n + 1 < TAPS) ? n + 1 : TAPS);
    return c;
  endfunction

  task automatic hostWrite(input bit sel, input int addr, input int re, input int im);
    @(negedge clk);
    hostWe = 1'b1; hostSel = sel; hostAddr = LOG2N'(addr);
    hostWrRe = DW'(re); hostWrIm = DW'(im);
    @(negedge clk);
    hostWe = 1'b0;
    if (sel) begin cRe[addr] = re; cIm[addr] = im; end
    else begin dRe[addr] = re; dIm[addr] = im; end
  endtask

  task automatic hostRead(input int addr, output int re, output int im);
    @(negedge clk);
    hostRdAddr = LOG2N'(addr);
    @(negedge clk);
    re = int'($signed(hostRdRe));
    im = int'($signed(hostRdIm));
  endtask

  task automatic loadData();
    for (int i = 0; i < N; i++) hostWrite(1'b0, i, dRe[i], dIm[i]);
  endtask

  task automatic loadTwiddles();
    for (int k = 0; k < N / 2; k++) begin
      real ang = 6.283185307179586 * k / N;
      hostWrite(1'b1, k, $rtoi(131071.0 * $cos(ang) + ((ang < 1.6 || ang > 4.7) ? 0.5 : -0.5)),
                -$rtoi(131071.0 * $sin(ang) + ((ang < 3.1) ? 0.5 : -0.5)));
    end
  endtask

  task automatic checkData(input string req);
    for (int i = 0; i < N; i++) begin
      int re, im;
      hostRead(i, re, im);
      check(req, $sformatf("re[%0d]", i), re, dRe[i]);
      check(req, $sformatf("im[%0d]", i), im, dIm[i]);
    end
  endtask

  // called at a negedge; raises start in that same cycle
  task automatic startRun(input bit m);
    mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R5", "busy after start", busy, 1);
  endtask

  // returns at the negedge of the done cycle
  task automatic waitDone(input bit noisy, output int cyc);
    cyc = 0;
    while (busy) begin
      cyc++;
      if (noisy && cyc == 10) begin
        start = 1'b1; mode = ~mode;
        hostWe = 1'b1; hostSel = 1'b0; hostAddr = 6'd5; hostWrRe = 18'h1234; hostWrIm = 18'h0777;
      end
      if (noisy && cyc == 11) begin
        start = 1'b0; hostSel = 1'b1; hostAddr = 6'd1;
      end
      if (noisy && cyc == 12) hostWe = 1'b0;
      @(negedge clk);
    end
    check("R5", "done with busy low", done, 1);
  endtask

  initial begin
    int cyc, re, im;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", busy, 0);
    check("R1", "done in reset", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "busy after reset", busy, 0);
    check("R1", "done after reset", done, 0);

    // R2 host write and readback
    for (int i = 0; i < N; i++) begin dRe[i] = rnd18(); dIm[i] = rnd18(); end
    loadData();
    for (int i = 0; i < 4; i++) begin
      int a = int'($urandom_range(0, N - 1));
      hostRead(a, re, im);
      check("R2", "readback re", re, dRe[a]);
      check("R2", "readback im", im, dIm[a]);
    end

    // R3 FFT on random data, plus R6 length
    loadTwiddles();
    @(negedge clk);
    startRun(1'b0);
    waitDone(1'b0, cyc);
    check("R6", "fft busy cycles", cyc, 2 * N + 3 * N * LOG2N);
    @(negedge clk);
    check("R5", "done one cycle", done, 0);
    modelFft();
    checkData("R3");

    // R3 directed impulse
    for (int i = 0; i < N; i++) begin dRe[i] = 0; dIm[i] = 0; end
    dRe[0] = 100000; dIm[0] = -50000;
    loadData();
    @(negedge clk);
    startRun(1'b0);
    waitDone(1'b0, cyc);
    modelFft();
    checkData("R3");

    // R7 start, mode and writes mid-run are ignored
    for (int i = 0; i < N; i++) begin dRe[i] = rnd18() / 2; dIm[i] = rnd18() / 2; end
    loadData();
    @(negedge clk);
    startRun(1'b0);
    waitDone(1'b1, cyc);
    check("R7", "busy cycles with noise", cyc, 2 * N + 3 * N * LOG2N);
    mode = 1'b0;
    @(negedge clk);
    check("R7", "no second run", busy, 0);
    modelFft();
    checkData("R7");

    // R4 FIR on random data and taps, then FFT chained in the done cycle
    for (int k = 0; k < TAPS; k++) hostWrite(1'b1, k, rnd18() / 4, rnd18() / 4);
    for (int i = 0; i < N; i++) begin dRe[i] = rnd18(); dIm[i] = rnd18(); end
    loadData();
    @(negedge clk);
    startRun(1'b1);
    waitDone(1'b0, cyc);
    check("R6", "fir busy cycles", cyc, firCycles());
    modelFir();
    startRun(1'b0);
    waitDone(1'b0, cyc);
    check("R6", "chained fft busy cycles", cyc, 2 * N + 3 * N * LOG2N);
    modelFft();
    checkData("R4");

    // R4 FIR alone on fresh data
    for (int i = 0; i < N; i++) begin dRe[i] = rnd18(); dIm[i] = rnd18(); end
    loadData();
    @(negedge clk);
    startRun(1'b1);
    waitDone(1'b0, cyc);
    modelFir();
    checkData("R4");

    // R8 saturation, both signs
    for (int k = 0; k < TAPS; k++) hostWrite(1'b1, k, 131071, 131071);
    for (int i = 0; i < N; i++) begin
      dRe[i] = (i < N / 2) ? 131071 : -131072;
      dIm[i] = dRe[i];
    end
    loadData();
    @(negedge clk);
    startRun(1'b1);
    waitDone(1'b0, cyc);
    modelFir();
    check("R8", "model reaches positive limit", dIm[20], 131071);
    check("R8", "model reaches negative limit", dIm[N - 1], -131072);
    checkData("R8");

    summary();
    $finish;
  end

endmodule